// File: doc/BRIEF.md
# Programmable Baud Rate Timer

This block produces the oversampling clock enable for a set of serial receivers and transmitters. One of eight source rates is picked: four fixed fractions of the system clock, a crystal-derived enable at full or half rate, and two external clock pins. Every pulse of the chosen source steps a down counter. The counter is reloaded from a 16-bit divisor. Each time the counter expires, a one-cycle 16x tick is emitted. A second divider turns every sixteenth 16x tick into a 1x bit tick.

A host writes three byte-wide registers: a control register and the high and low bytes of the divisor. Clearing the run bit resets the counter and the bit divider and holds them there. Setting it starts a fresh count. A divisor of zero counts 65536 source pulses. A divisor change made while the counter runs is only picked up at the next reload. While the timer is stopped it is picked up at once. The two external pins are treated as asynchronous: each passes through a two-flop synchroniser, and its rising edges become single-cycle enables.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset the run bit is 0, the select code is 0, and both tick outputs are low. No tick appears until the run bit is set.
- R2: A write with `wr_addr`=0 loads the control register: bit 0 is run and bits 3:1 are the select code. Address 1 loads the divisor high byte (divisor bits 15:8). Address 2 loads the low byte (bits 7:0). A write to address 3 changes nothing.
- R3: Select codes 0, 1, 2 and 3 take one source pulse every 16, 32, 64 and 128 system clock cycles.
- R4: Select code 4 takes every cycle in which `xtal_en` is high. Select code 5 takes every second such cycle.
- R5: Select codes 6 and 7 take one source pulse per rising edge of `pin_clk` and `gen_clk` respectively, after a two-flop synchroniser. An edge never gives two pulses in a row.
- R6: While running with divisor D (1 to 65535), `tick16_o` is high for exactly one cycle every D source pulses.
- R7: A divisor of 0 counts 65536 source pulses per `tick16_o`.
- R8: While run is 0, `tick16_o` and `tick1_o` stay low and the counter stays reset. After run is set, the first `tick16_o` is high in the cycle that follows the D-th source pulse. With `xtal_en` held high and code 4, that is D cycles after the control write's clock edge.
- R9: A divisor written while the counter runs does not change the count in progress. It is used from the next reload on.
- R10: `tick1_o` is high for one cycle, in the cycle after every sixteenth `tick16_o` since run was set. It is never high when `tick16_o` was not high the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| xtal_en | input | 1 | Crystal-derived clock enable, already in the `clk` domain |
| pin_clk | input | 1 | Asynchronous clock from an I/O pin |
| gen_clk | input | 1 | Asynchronous general-purpose input clock |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 control, 1 divisor high, 2 divisor low |
| wr_data | input | 8 | Register write data |
| tick16_o | output | 1 | One-cycle 16x sampling tick |
| tick1_o | output | 1 | One-cycle bit-rate tick, one per 16 `tick16_o` |

## Verification
The bench builds the block with its default parameters: byte-wide registers, a 16-bit divisor, 16x oversampling, two synchroniser stages and a smallest prescale of 16. The crystal enable can be held high so that the source steps every cycle. That brings the 65536-count divisor-zero case within a short run, and it makes start-up latency exact to the cycle. The external pins are toggled away from clock edges at fixed rates, so the measured tick spacing for every select code has one exact expected value.

// File: rtl/bt_pkg.sv
package bt_pkg;

  localparam int unsigned PRE_BASE_LOG = 4;
  localparam int unsigned PRE_W        = PRE_BASE_LOG + 3;

  typedef enum logic [2:0] {
    SEL_SYS16  = 3'd0,
    SEL_SYS32  = 3'd1,
    SEL_SYS64  = 3'd2,
    SEL_SYS128 = 3'd3,
    SEL_XTAL   = 3'd4,
    SEL_XTAL2  = 3'd5,
    SEL_PIN    = 3'd6,
    SEL_GEN    = 3'd7
  } src_sel_e;

  // The prescaler hits once every 2^(PRE_BASE_LOG+step) cycles, when all low bits are ones
  function automatic logic prescale_hit(input logic [PRE_W-1:0] pre, input logic [1:0] step);
    logic [PRE_W-1:0] mask;
    mask = PRE_W'((1 << (PRE_BASE_LOG + int'(step))) - 1);
    return (pre & mask) == mask;
  endfunction

endpackage

// File: rtl/bt_edge_sync.sv
module bt_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic pulse_o
);

  logic [STAGES:0] sync_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-1:0], async_in};
    end
  end

  assign pulse_o = sync_q[STAGES-1] & ~sync_q[STAGES];

endmodule

// File: rtl/bt_src_sel.sv
module bt_src_sel #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel,
  input  logic       xtal_en,
  input  logic       pin_clk,
  input  logic       gen_clk,
  output logic       src_en_o,
  output logic       pin_pulse_o,
  output logic       gen_pulse_o
);
  import bt_pkg::*;

  localparam int unsigned N_EXT = 2;

  logic [PRE_W-1:0] pre_q;
  logic             half_q;
  logic [N_EXT-1:0] ext_in;
  logic [N_EXT-1:0] ext_pulse;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q  <= '0;
      half_q <= 1'b0;
    end else begin
      pre_q <= pre_q + 1'b1;
      if (xtal_en) half_q <= ~half_q;
    end
  end

  assign ext_in = {gen_clk, pin_clk};

  for (genvar g = 0; g < N_EXT; g++) begin : g_ext
    bt_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (ext_in[g]),
      .pulse_o  (ext_pulse[g])
    );
  end

  assign pin_pulse_o = ext_pulse[0];
  assign gen_pulse_o = ext_pulse[1];

  always_comb begin
    case (src_sel_e'(sel))
      SEL_SYS16:  src_en_o = prescale_hit(pre_q, 2'd0);
      SEL_SYS32:  src_en_o = prescale_hit(pre_q, 2'd1);
      SEL_SYS64:  src_en_o = prescale_hit(pre_q, 2'd2);
      SEL_SYS128: src_en_o = prescale_hit(pre_q, 2'd3);
      SEL_XTAL:   src_en_o = xtal_en;
      SEL_XTAL2:  src_en_o = xtal_en & half_q;
      SEL_PIN:    src_en_o = ext_pulse[0];
      default:    src_en_o = ext_pulse[1];
    endcase
  end

endmodule

// File: rtl/bt_div_counter.sv
module bt_div_counter #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             src_en,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick_o
);

  // A zero divisor wraps to all ones, so it counts 2^DIV_W pulses
  function automatic logic [DIV_W-1:0] reload_of(input logic [DIV_W-1:0] d);
    return d - 1'b1;
  endfunction

  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (!run) begin
      cnt_q  <= reload_of(divisor);
      tick_o <= 1'b0;
    end else begin
      tick_o <= 1'b0;
      if (src_en) begin
        if (cnt_q == '0) begin
          tick_o <= 1'b1;
          cnt_q  <= reload_of(divisor);
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/bt_bit_div.sv
module bt_bit_div #(
  parameter int unsigned OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick16,
  output logic tick1_o
);

  localparam int unsigned CW = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt_q   <= '0;
      tick1_o <= 1'b0;
    end else begin
      tick1_o <= tick16 && (cnt_q == LAST);
      if (tick16) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned OVS         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xtal_en,
  input  logic              pin_clk,
  input  logic              gen_clk,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              tick16_o,
  output logic              tick1_o
);

  localparam int unsigned DIV_W = 2 * DATA_W;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_HI   = 2'd1;
  localparam logic [1:0] ADDR_LO   = 2'd2;

  logic              run_q;
  logic [2:0]        sel_q;
  logic [DATA_W-1:0] div_hi_q;
  logic [DATA_W-1:0] div_lo_q;
  logic [DIV_W-1:0]  divisor_w;
  logic              src_en_w;
  logic              pin_pulse_w;
  logic              gen_pulse_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      sel_q    <= '0;
      div_hi_q <= '0;
      div_lo_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_CTRL: begin
          run_q <= wr_data[0];
          sel_q <= wr_data[3:1];
        end
        ADDR_HI: div_hi_q <= wr_data;
        ADDR_LO: div_lo_q <= wr_data;
        default: ;
      endcase
    end
  end

  assign divisor_w = {div_hi_q, div_lo_q};

  bt_src_sel #(.SYNC_STAGES(SYNC_STAGES)) i_src (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel         (sel_q),
    .xtal_en     (xtal_en),
    .pin_clk     (pin_clk),
    .gen_clk     (gen_clk),
    .src_en_o    (src_en_w),
    .pin_pulse_o (pin_pulse_w),
    .gen_pulse_o (gen_pulse_w)
  );

  bt_div_counter #(.DIV_W(DIV_W)) i_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run_q),
    .src_en  (src_en_w),
    .divisor (divisor_w),
    .tick_o  (tick16_o)
  );

  bt_bit_div #(.OVS(OVS)) i_bit (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run_q),
    .tick16  (tick16_o),
    .tick1_o (tick1_o)
  );

endmodule

// File: rtl/bt_checker.sv
module bt_checker (
  input logic clk,
  input logic rst_n,
  input logic run,
  input logic src_en,
  input logic pin_pulse,
  input logic gen_pulse,
  input logic tick16,
  input logic tick1
);

  AST_STOP_SILENCES_TICK16: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !tick16); // R8

  AST_STOP_SILENCES_TICK1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !tick1); // R10

  AST_TICK_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tick16) |-> $past(src_en)); // R6

  AST_BIT_FOLLOWS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    tick1 |-> $past(tick16)); // R10

  AST_PIN_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    pin_pulse |=> !pin_pulse); // R5

  AST_GEN_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    gen_pulse |=> !gen_pulse); // R5

endmodule

bind baud_tick_gen bt_checker i_bt_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .run       (run_q),
  .src_en    (src_en_w),
  .pin_pulse (pin_pulse_w),
  .gen_pulse (gen_pulse_w),
  .tick16    (tick16_o),
  .tick1     (tick1_o)
);

// File: tb/test_baud_tick_gen.sv
module test_baud_tick_gen;

  localparam int CLK_P = 10;
  localparam int LIMIT = 70000;
  localparam int N_VEC = 8;

  // {select code, divisor, expected clk cycles between tick16 pulses}
  localparam logic [38:0] VEC [N_VEC] = '{
    {3'd0, 16'd3, 20'd48},
    {3'd1, 16'd2, 20'd64},
    {3'd2, 16'd1, 20'd64},
    {3'd3, 16'd1, 20'd128},
    {3'd4, 16'd4, 20'd12},
    {3'd5, 16'd2, 20'd12},
    {3'd6, 16'd3, 20'd30},
    {3'd7, 16'd2, 20'd16}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       xtal_en = 1'b0;
  logic       pin_clk = 1'b0;
  logic       gen_clk = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       tick16_o;
  logic       tick1_o;

  int  total = 0;
  int  bad = 0;
  int  cyc = 0;
  int  wr_cyc = 0;
  bit  xtal_const = 1'b0;
  int  xcnt = 0;

  baud_tick_gen i_baud_tick_gen (
    .clk(clk), .rst_n(rst_n), .xtal_en(xtal_en), .pin_clk(pin_clk),
    .gen_clk(gen_clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tick16_o(tick16_o), .tick1_o(tick1_o)
  );

  always #(CLK_P/2) clk = ~clk;

  initial begin
    #3;
    forever #50 pin_clk = ~pin_clk;
  end

  initial begin
    #3;
    forever #40 gen_clk = ~gen_clk;
  end

  always @(posedge clk) begin
    cyc     <= cyc + 1;
    xcnt    <= (xcnt == 2) ? 0 : xcnt + 1;
    xtal_en <= xtal_const ? 1'b1 : (xcnt == 2);
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    wr_cyc = cyc;
  endtask

  task automatic set_div(input logic [15:0] d);
    reg_write(2'd1, d[15:8]);
    reg_write(2'd2, d[7:0]);
  endtask

  task automatic wait_t16(output int at);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!tick16_o && n < LIMIT);
    if (!tick16_o) check(1'b0, "timeout waiting tick16", n, LIMIT);
    at = cyc;
  endtask

  task automatic wait_t1(output int at);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!tick1_o && n < LIMIT);
    if (!tick1_o) check(1'b0, "timeout waiting tick1", n, LIMIT);
    at = cyc;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int t0, t1, t2, hits;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state, no ticks while idle even with a fast source
    check(tick16_o == 1'b0, "R1 tick16 after reset", tick16_o, 0);
    check(tick1_o == 1'b0, "R1 tick1 after reset", tick1_o, 0);
    xtal_const = 1'b1;
    set_div(16'd1);
    hits = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (tick16_o || tick1_o) hits++;
    end
    check(hits == 0, "R1 idle after reset", hits, 0);
    xtal_const = 1'b0;

    // R3 R4 R5 R6: table of source/divisor/period
    for (int v = 0; v < N_VEC; v++) begin
      logic [2:0]  s;
      logic [15:0] d;
      int          p;
      s = VEC[v][38:36];
      d = VEC[v][35:20];
      p = int'(VEC[v][19:0]);
      reg_write(2'd0, 8'h00);
      set_div(d);
      reg_write(2'd0, {4'b0, s, 1'b1});
      wait_t16(t0);
      wait_t16(t1);
      wait_t16(t2);
      check(t1 - t0 == p, $sformatf("R3/R4/R5 R6 sel=%0d first interval", s), t1 - t0, p);
      check(t2 - t1 == p, $sformatf("R6 sel=%0d second interval", s), t2 - t1, p);
    end

    // R8: latency from run to first tick with one source pulse per cycle
    xtal_const = 1'b1;
    reg_write(2'd0, 8'h00);
    set_div(16'd5);
    reg_write(2'd0, {4'b0, 3'd4, 1'b1});
    wait_t16(t0);
    check(t0 - wr_cyc == 5, "R8 first tick latency D=5", t0 - wr_cyc, 5);

    // R2: high byte position, divisor 0x0100
    reg_write(2'd0, 8'h00);
    set_div(16'h0100);
    reg_write(2'd0, {4'b0, 3'd4, 1'b1});
    wait_t16(t0);
    check(t0 - wr_cyc == 256, "R2 high byte divisor 256", t0 - wr_cyc, 256);

    // R7: divisor zero counts 65536
    reg_write(2'd0, 8'h00);
    set_div(16'h0000);
    reg_write(2'd0, {4'b0, 3'd4, 1'b1});
    wait_t16(t0);
    check(t0 - wr_cyc == 65536, "R7 divisor zero", t0 - wr_cyc, 65536);

    // R9: divisor change mid-count waits for the next reload
    reg_write(2'd0, 8'h00);
    set_div(16'd20);
    reg_write(2'd0, {4'b0, 3'd4, 1'b1});
    wait_t16(t0);
    reg_write(2'd2, 8'd6);
    wait_t16(t1);
    wait_t16(t2);
    check(t1 - t0 == 20, "R9 count in progress kept", t1 - t0, 20);
    check(t2 - t1 == 6, "R9 new divisor after reload", t2 - t1, 6);

    // R2: address 3 write has no effect on the period
    reg_write(2'd3, 8'h01);
    wait_t16(t0);
    wait_t16(t1);
    check(t1 - t0 == 6, "R2 address 3 ignored", t1 - t0, 6);

    // R10: bit tick every 16 tick16 pulses, one cycle wide
    reg_write(2'd0, 8'h00);
    set_div(16'd1);
    reg_write(2'd0, {4'b0, 3'd4, 1'b1});
    wait_t1(t0);
    check(t0 - wr_cyc == 17, "R10 first tick1 latency", t0 - wr_cyc, 17);
    @(negedge clk);
    check(tick1_o == 1'b0, "R10 tick1 one cycle wide", tick1_o, 0);
    wait_t1(t1);
    check(t1 - t0 == 16, "R10 tick1 period", t1 - t0, 16);

    // R8: stopping silences both outputs
    reg_write(2'd0, {4'b0, 3'd4, 1'b0});
    hits = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (tick16_o || tick1_o) hits++;
    end
    check(hits == 0, "R8 stopped no ticks", hits, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule